// File: doc/BRIEF.md
# VME A24 Slave Address Decoder

This block sits at the edge of a board that bridges a VME backplane onto an internal local bus. It watches each VME A24 bus cycle, decides whether the cycle is meant for this board, and, if it is, tells the local bus which device is addressed, which local word address is wanted and whether the cycle is a read or a write. A board answers only in its own slot. To check this, the 5-bit slot field at the top of the address is compared with the inverse of the active-low geographic address pins. A fixed set of address modifiers is accepted. There is no programmable base-address register.

All bus inputs pass through two flip-flops into the local clock domain. The decode is taken when the synchronised address strobe falls, and it is held unchanged until the strobe rises again. While it is held, the local side sees a one-hot device select, a 15-bit local address, a cycle-valid flag, a write flag and a data-strobe qualifier. Data transfer timing, acknowledge generation and the device back-ends belong to other blocks.

Top module: `vme_a24_decoder`

## Requirements
- R1: A cycle is valid only when address bits 23:19 equal the bitwise inverse of `vme_ga_n`; otherwise `cyc_valid` stays 0 and `lb_dev_sel` stays all zero.
- R2: Only address modifier codes 0x39, 0x3A, 0x3D and 0x3E are accepted; any other code leaves all outputs at zero.
- R3: Address bits 18:15 form a device code, and bit n of `lb_dev_sel` is set for code n. Codes 0, 1, 2, 4 to 13 are populated: 0 is the control/status registers, 1 and 2 are the upper and lower FPGA, 4 and 5 are the upper and lower flash, 6 and 7 are the upper and lower indirect spaces, and 8 to 13 are the six auxiliary links. Codes 3, 14 and 15 give no select and no valid cycle. At most one select bit is ever set.
- R4: For a valid cycle, `lb_addr` equals address bits 14:0 unchanged. For any cycle that is not valid it is zero.
- R5: The decode is captured when the synchronised address strobe falls, about three clock edges after `vme_as_n` goes low. Address, modifier and write changes while the strobe stays low have no effect on the outputs.
- R6: When the synchronised address strobe rises, `cyc_valid`, `lb_dev_sel`, `lb_addr` and `lb_write` return to zero.
- R7: `lb_write` is 1 for a valid cycle with `vme_write_n` low at capture, and 0 otherwise.
- R8: `lb_ds` is 1 only while `cyc_valid` is 1 and at least one synchronised data strobe is low.
- R9: While `rst_n` is low, all outputs are zero.
- R10: `cyc_valid` is 1 exactly when `lb_dev_sel` has a bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vme_addr | input | 24 | VME address lines, asynchronous |
| vme_am | input | 6 | Address modifier code |
| vme_ga_n | input | 5 | Geographic address pins, active low |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 2 | Data strobes, active low |
| vme_write_n | input | 1 | Low for a write cycle |
| lb_dev_sel | output | 16 | One-hot local device select, indexed by device code |
| lb_addr | output | 15 | Local word address |
| cyc_valid | output | 1 | Cycle addressed to this board |
| lb_write | output | 1 | Captured direction, 1 = write |
| lb_ds | output | 1 | Data strobe qualified by a valid cycle |

## Verification
On every cycle the assertions check these output properties: the device select is one-hot or zero and agrees with the valid flag, the outputs hold still between strobe edges, the outputs clear on the strobe's rising edge, the captured address matches the decoder at the falling edge, and the data-strobe qualifier is never active without a valid cycle. The bench's scenarios cover what depends on stimulus values. These are the slot comparison against the inverted pins, the accepted modifier codes, the map from every device code to its select bit (including the three empty codes), the address pass-through, the direction, and the outputs ignoring address changes in the middle of a cycle.

// File: rtl/vad_pkg.sv
package vad_pkg;

  localparam int ADDR_W = 24;
  localparam int AM_W   = 6;
  localparam int SLOT_W = 5;
  localparam int DEV_W  = 4;
  localparam int LB_W   = 15;
  localparam int DS_W   = 2;

  // Accepted A24 modifier codes (data and program, user and supervisor)
  function automatic logic am_accept(input logic [AM_W-1:0] am);
    case (am)
      6'h39, 6'h3A, 6'h3D, 6'h3E: am_accept = 1'b1;
      default:                    am_accept = 1'b0;
    endcase
  endfunction

  // Populated device codes: 0..13 except 3
  function automatic logic dev_present(input int code);
    dev_present = (code >= 0) && (code <= 13) && (code != 3);
  endfunction

  // Slot field equals inverted geographic address pins
  function automatic logic slot_match(input logic [SLOT_W-1:0] slot,
                                      input logic [SLOT_W-1:0] ga_n);
    slot_match = (slot == ~ga_n);
  endfunction

endpackage

// File: rtl/vad_sync.sv
module vad_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end

endmodule

// File: rtl/vad_decode.sv
module vad_decode
  import vad_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W,
  parameter int SLOT_W_P = SLOT_W,
  parameter int DEV_W_P  = DEV_W,
  parameter int LB_W_P   = LB_W,
  localparam int DEV_LSB = LB_W_P,
  localparam int SLOT_LSB = LB_W_P + DEV_W_P,
  localparam int DEV_N   = 1 << DEV_W_P
) (
  input  logic [ADDR_W_P-1:0] addr,
  input  logic [AM_W-1:0]     am,
  input  logic [SLOT_W_P-1:0] ga_n,
  output logic                dec_valid,
  output logic [DEV_N-1:0]    dec_sel,
  output logic [LB_W_P-1:0]   dec_addr
);

  logic [SLOT_W_P-1:0] slot_fld;
  logic [DEV_W_P-1:0]  dev_fld;
  logic                slot_hit;
  logic                am_hit;
  logic [DEV_N-1:0]    dev_hit;

  assign slot_fld = addr[SLOT_LSB +: SLOT_W_P];
  assign dev_fld  = addr[DEV_LSB +: DEV_W_P];
  assign slot_hit = (slot_fld == ~ga_n);
  assign am_hit   = am_accept(am);

  // One comparator per device code; unpopulated codes tie off
  for (genvar g = 0; g < DEV_N; g++) begin : g_dev
    if (dev_present(g)) begin : g_pop
      assign dev_hit[g] = (dev_fld == DEV_W_P'(g));
    end else begin : g_empty
      assign dev_hit[g] = 1'b0;
    end
  end

  assign dec_sel   = (slot_hit && am_hit) ? dev_hit : '0;
  assign dec_valid = slot_hit && am_hit && dev_present(int'(dev_fld));
  assign dec_addr  = dec_valid ? addr[LB_W_P-1:0] : '0;

endmodule

// File: rtl/vad_hold.sv
module vad_hold #(
  parameter int DEV_N  = 16,
  parameter int LB_W_P = 15,
  parameter int DS_W_P = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n_s,
  input  logic [DS_W_P-1:0] ds_n_s,
  input  logic              write_n_s,
  input  logic              dec_valid,
  input  logic [DEV_N-1:0]  dec_sel,
  input  logic [LB_W_P-1:0] dec_addr,
  output logic              as_fall_evt,
  output logic              as_rise_evt,
  output logic              cyc_valid,
  output logic [DEV_N-1:0]  lb_dev_sel,
  output logic [LB_W_P-1:0] lb_addr,
  output logic              lb_write,
  output logic              lb_ds
);

  logic as_prev;

  assign as_fall_evt = as_prev && !as_n_s;
  assign as_rise_evt = !as_prev && as_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_prev    <= 1'b1;
      cyc_valid  <= 1'b0;
      lb_dev_sel <= '0;
      lb_addr    <= '0;
      lb_write   <= 1'b0;
    end else begin
      as_prev <= as_n_s;
      if (as_fall_evt) begin
        cyc_valid  <= dec_valid;
        lb_dev_sel <= dec_sel;
        lb_addr    <= dec_addr;
        lb_write   <= dec_valid && !write_n_s;
      end else if (as_rise_evt) begin
        cyc_valid  <= 1'b0;
        lb_dev_sel <= '0;
        lb_addr    <= '0;
        lb_write   <= 1'b0;
      end
    end
  end

  assign lb_ds = cyc_valid && !(&ds_n_s);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_fall_evt && !as_rise_evt) |=> ($stable(cyc_valid) && $stable(lb_addr)
                                        && $stable(lb_dev_sel) && $stable(lb_write))); // R5

  AST_CAPTURE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    as_fall_evt |=> (lb_addr == $past(dec_addr))); // R5

  AST_CLEAR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    as_rise_evt |=> (!cyc_valid && lb_dev_sel == '0 && !lb_write)); // R6

  AST_DS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    lb_ds |-> cyc_valid); // R8

endmodule

// File: rtl/vme_a24_decoder.sv
module vme_a24_decoder
  import vad_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W,
  parameter int SLOT_W_P = SLOT_W,
  parameter int DEV_W_P  = DEV_W,
  parameter int LB_W_P   = LB_W,
  parameter int DS_W_P   = DS_W,
  localparam int DEV_N   = 1 << DEV_W_P
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W_P-1:0] vme_addr,
  input  logic [AM_W-1:0]     vme_am,
  input  logic [SLOT_W_P-1:0] vme_ga_n,
  input  logic                vme_as_n,
  input  logic [DS_W_P-1:0]   vme_ds_n,
  input  logic                vme_write_n,
  output logic [DEV_N-1:0]    lb_dev_sel,
  output logic [LB_W_P-1:0]   lb_addr,
  output logic                cyc_valid,
  output logic                lb_write,
  output logic                lb_ds
);

  logic [ADDR_W_P-1:0] addr_s;
  logic [AM_W-1:0]     am_s;
  logic [SLOT_W_P-1:0] ga_n_s;
  logic                as_n_s;
  logic [DS_W_P-1:0]   ds_n_s;
  logic                write_n_s;

  vad_sync #(.W(ADDR_W_P), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d_async(vme_addr), .q_sync(addr_s));
  vad_sync #(.W(AM_W), .RST_VAL('0)) u_sync_am (
    .clk(clk), .rst_n(rst_n), .d_async(vme_am), .q_sync(am_s));
  vad_sync #(.W(SLOT_W_P), .RST_VAL('1)) u_sync_ga (
    .clk(clk), .rst_n(rst_n), .d_async(vme_ga_n), .q_sync(ga_n_s));
  vad_sync #(.W(1), .RST_VAL(1'b1)) u_sync_as (
    .clk(clk), .rst_n(rst_n), .d_async(vme_as_n), .q_sync(as_n_s));
  vad_sync #(.W(DS_W_P), .RST_VAL('1)) u_sync_ds (
    .clk(clk), .rst_n(rst_n), .d_async(vme_ds_n), .q_sync(ds_n_s));
  vad_sync #(.W(1), .RST_VAL(1'b1)) u_sync_wr (
    .clk(clk), .rst_n(rst_n), .d_async(vme_write_n), .q_sync(write_n_s));

  logic             dec_valid;
  logic [DEV_N-1:0] dec_sel;
  logic [LB_W_P-1:0] dec_addr;
  logic             as_fall_evt;
  logic             as_rise_evt;

  vad_decode #(
    .ADDR_W_P(ADDR_W_P), .SLOT_W_P(SLOT_W_P), .DEV_W_P(DEV_W_P), .LB_W_P(LB_W_P)
  ) u_decode (
    .addr(addr_s), .am(am_s), .ga_n(ga_n_s),
    .dec_valid(dec_valid), .dec_sel(dec_sel), .dec_addr(dec_addr)
  );

  vad_hold #(.DEV_N(DEV_N), .LB_W_P(LB_W_P), .DS_W_P(DS_W_P)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .as_n_s(as_n_s), .ds_n_s(ds_n_s), .write_n_s(write_n_s),
    .dec_valid(dec_valid), .dec_sel(dec_sel), .dec_addr(dec_addr),
    .as_fall_evt(as_fall_evt), .as_rise_evt(as_rise_evt),
    .cyc_valid(cyc_valid), .lb_dev_sel(lb_dev_sel), .lb_addr(lb_addr),
    .lb_write(lb_write), .lb_ds(lb_ds)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lb_dev_sel)); // R3

  AST_VALID_MATCHES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid == (lb_dev_sel != '0)); // R10

  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lb_write |-> cyc_valid); // R7

  AST_ADDR_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> (lb_addr == '0)); // R4

endmodule

// File: tb/vme_a24_decoder_bench.sv
module vme_a24_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] vme_addr = '0;
  logic [5:0]  vme_am = '0;
  logic [4:0]  vme_ga_n = ~5'd4;
  logic        vme_as_n = 1'b1;
  logic [1:0]  vme_ds_n = 2'b11;
  logic        vme_write_n = 1'b1;
  logic [15:0] lb_dev_sel;
  logic [14:0] lb_addr;
  logic        cyc_valid;
  logic        lb_write;
  logic        lb_ds;

  always #10 clk = ~clk; // 50 MHz

  vme_a24_decoder u_vme_a24_decoder (
    .clk(clk), .rst_n(rst_n), .vme_addr(vme_addr), .vme_am(vme_am),
    .vme_ga_n(vme_ga_n), .vme_as_n(vme_as_n), .vme_ds_n(vme_ds_n),
    .vme_write_n(vme_write_n), .lb_dev_sel(lb_dev_sel), .lb_addr(lb_addr),
    .cyc_valid(cyc_valid), .lb_write(lb_write), .lb_ds(lb_ds)
  );

  typedef struct {
    logic        valid;
    logic [15:0] sel;
    logic [14:0] addr;
    logic        wr;
    logic        ds;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  event  sample_ev;
  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;

  // Independent model of the decode rules
  function automatic exp_t model(input logic [23:0] a, input logic [5:0] am,
                                 input logic [4:0] ga_n, input logic wr_n,
                                 input logic [1:0] ds_n);
    exp_t e;
    int code;
    bit am_ok, slot_ok, dev_ok;
    code    = int'(a[18:15]);
    am_ok   = (am == 6'h39) || (am == 6'h3A) || (am == 6'h3D) || (am == 6'h3E);
    slot_ok = (a[23:19] == (5'h1F ^ ga_n));
    dev_ok  = !(code == 3 || code == 14 || code == 15);
    e.valid = am_ok && slot_ok && dev_ok;
    e.sel   = e.valid ? (16'h1 << code) : 16'h0;
    e.addr  = e.valid ? a[14:0] : 15'h0;
    e.wr    = e.valid && !wr_n;
    e.ds    = e.valid && (ds_n != 2'b11);
    return e;
  endfunction

  function automatic exp_t idle_exp();
    exp_t e;
    e.valid = 0; e.sel = '0; e.addr = '0; e.wr = 0; e.ds = 0;
    return e;
  endfunction

  task automatic check1(input string what, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, expv);
    end
  endtask

  // Monitor: pops expectations and compares at sample points
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check1({t, " R1 R2 valid"},  32'(cyc_valid),  32'(e.valid));
        check1({t, " R3 dev_sel"},   32'(lb_dev_sel), 32'(e.sel));
        check1({t, " R4 lb_addr"},   32'(lb_addr),    32'(e.addr));
        check1({t, " R7 lb_write"},  32'(lb_write),   32'(e.wr));
        check1({t, " R8 lb_ds"},     32'(lb_ds),      32'(e.ds));
      end
    end
  end

  task automatic expect_now(input exp_t e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> sample_ev;
    #1;
  endtask

  // Driver: one full strobe cycle with mid-cycle disturbance and release
  task automatic bus_cycle(input logic [23:0] a, input logic [5:0] am,
                           input logic wr_n, input logic [1:0] ds_n, input string t);
    exp_t e;
    e = model(a, am, vme_ga_n, wr_n, ds_n);
    @(negedge clk);
    vme_addr = a; vme_am = am; vme_write_n = wr_n;
    repeat (3) @(negedge clk);
    vme_as_n = 1'b0; vme_ds_n = ds_n;
    repeat (5) @(negedge clk);
    expect_now(e, t);
    // R5: address, modifier and direction change while strobe low
    vme_addr = ~a; vme_am = 6'h09; vme_write_n = ~wr_n;
    repeat (5) @(negedge clk);
    expect_now(e, {t, " R5 hold"});
    vme_as_n = 1'b1; vme_ds_n = 2'b11;
    repeat (5) @(negedge clk);
    expect_now(idle_exp(), {t, " R6 clear"});
  endtask

  function automatic logic [23:0] mk(input int slot, input int dev, input int la);
    return 24'((slot << 19) | (dev << 15) | la);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    expect_now(idle_exp(), "R9 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: every device code, slot 4
    for (int d = 0; d < 16; d++)
      bus_cycle(mk(4, d, 4 * d + 8), 6'h39, 1'b1, 2'b00, "R3 code sweep");

    // R2: modifier codes
    bus_cycle(mk(4, 1, 12'h120), 6'h3A, 1'b0, 2'b00, "R2 am 3A");
    bus_cycle(mk(4, 2, 12'h124), 6'h3D, 1'b1, 2'b00, "R2 am 3D");
    bus_cycle(mk(4, 4, 12'h128), 6'h3E, 1'b0, 2'b00, "R2 am 3E");
    bus_cycle(mk(4, 1, 12'h120), 6'h38, 1'b0, 2'b00, "R2 am 38");
    bus_cycle(mk(4, 1, 12'h120), 6'h3B, 1'b0, 2'b00, "R2 am 3B");
    bus_cycle(mk(4, 1, 12'h120), 6'h3F, 1'b1, 2'b00, "R2 am 3F");
    bus_cycle(mk(4, 1, 12'h120), 6'h0D, 1'b1, 2'b00, "R2 am 0D");

    // R1: slot mismatch and other slot
    bus_cycle(mk(5, 1, 12'h020), 6'h39, 1'b1, 2'b00, "R1 wrong slot");
    bus_cycle(mk(27, 6, 12'h03C), 6'h39, 1'b1, 2'b00, "R1 inverse slot");
    vme_ga_n = ~5'd12;
    repeat (4) @(negedge clk);
    bus_cycle(mk(12, 6, 12'h03C), 6'h39, 1'b0, 2'b00, "R1 slot 12");
    bus_cycle(mk(4, 6, 12'h03C), 6'h39, 1'b0, 2'b00, "R1 old slot");

    // R4 address patterns, R7 direction, R8 strobes
    bus_cycle(mk(12, 13, 15'h7FFF), 6'h3D, 1'b0, 2'b00, "R4 all ones");
    bus_cycle(mk(12, 8, 15'h5555), 6'h39, 1'b1, 2'b00, "R4 alt");
    bus_cycle(mk(12, 0, 15'h0001), 6'h39, 1'b0, 2'b10, "R8 one ds");
    bus_cycle(mk(12, 7, 15'h2AAA), 6'h39, 1'b0, 2'b11, "R8 no ds");
    bus_cycle(mk(12, 14, 15'h1234), 6'h39, 1'b0, 2'b00, "R8 empty code");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule